// File: doc/BRIEF.md
# Strobe-to-Clock Leveling Trainer

This block trains the launch delay of the outgoing data strobe of each byte lane, so that the strobe's rising edge lines up with the memory clock as the clock arrives at the device. A single start pulse runs the whole procedure. First, a mode-register command puts the device into its leveling state. Then, for one lane at a time, the block fires a strobe request. It collects a set of one-bit clock samples that the device returns on the data lines, takes a majority vote on them, and moves the lane's delay code on. It stops when the sampled clock level turns from low to high. After the last lane it issues a second mode-register command that takes the device out of the leveling state, and then it reports completion.

The analog delay lines are outside this block. They are set from the per-lane delay codes. A front end outside the block turns each strobe request into pulses and passes the returned samples back through a valid/bit pair. The block also has a register that holds the settling time between strobe groups.

Top module: `wl_level_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `cmd_req`, `dqs_fire` and all `lane_err` bits are 0, and every lane code in `dly_code` is 0.
- R2: A start pulse accepted while the block is idle or done raises `cmd_req` with `cmd_mr_sel` = 1 and bit 7 of `cmd_mr_data` at 1, with all other data bits 0. The command and its data stay stable until `cmd_ack` is seen high.
- R3: Each delay step raises `dqs_fire` for exactly one cycle and then accepts exactly 4 samples on `fb_valid`/`fb_bit`. The step's verdict is 1 only when more than half of the samples are 1, so a 2-to-2 tie counts as 0.
- R4: The lane code starts at 0 and rises by one per step. A lane passes when a verdict of 1 follows an earlier verdict of 0 in the same lane. Its code then stays at the value that gave the 1, so a device that flips at threshold T in the range 1 to 127 leaves code T.
- R5: A verdict of 1 before any 0 has been seen in the lane does not pass the lane. The code keeps rising.
- R6: If code 127 is evaluated without a pass, the lane's `lane_err` bit is set and its code returns to 0. Training then moves on to the next lane.
- R7: Lanes are trained in order 0 to NUM_LANES-1, and `lane_sel` names the lane being trained. Lane i's code sits at `dly_code[i*7 +: 7]`, and only the selected lane's code changes.
- R8: The settling time W comes from a register whose reset value is 16 and which `wait_we`/`wait_val` overwrites. After the cycle that accepts a step's last sample, `dqs_fire` for the next step comes W+2 cycles later (W of 0 acts as 1).
- R9: After the last lane, `cmd_req` is raised with `cmd_mr_sel` = 1 and `cmd_mr_data` all 0. `done` rises only after that command is acknowledged, and it stays high until the next start.
- R10: An accepted start clears all lane codes and error bits by the next cycle. A start while `busy` is high has no effect on the run, its results or its command count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a training run |
| wait_we | input | 1 | Write enable for the settling-time register |
| wait_val | input | WAIT_W | New settling time in cycles |
| cmd_req | output | 1 | Mode-register write request |
| cmd_ack | input | 1 | Command accepted |
| cmd_mr_sel | output | 3 | Mode register number (always 1) |
| cmd_mr_data | output | MR_W | Mode register data, leveling flag at bit 7 |
| dqs_fire | output | 1 | Request one strobe group |
| lane_sel | output | LANE_W | Lane currently trained |
| fb_valid | input | 1 | A returned clock sample is present |
| fb_bit | input | 1 | Returned clock sample level |
| dly_code | output | NUM_LANES*DLY_W | Per-lane strobe delay codes |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, leveling state exited |
| lane_err | output | NUM_LANES | Lane found no low-to-high transition |

## Verification
Several properties are checked on every cycle: the command holds steady while it waits for acknowledgement, each strobe request lasts a single cycle and never overlaps a command, a lane code only ever steps up by one or drops to zero, codes of lanes that are not selected stay frozen, `done` rises only right after the exit command is accepted, and error bits fall only after a start. Other behaviour shows only in the bench's scenarios. These cover the stored code for a given device threshold, majority filtering of a flipped sample, the early-one case and the out-of-range case that fail a lane, the exact settling gap under default and programmed values, and a start ignored in the middle of a run.

// File: rtl/wl_level_pkg.sv
// Shared types for the leveling trainer.
// Assumes: one sequencer state type is shared by the top and its checker.
package wl_level_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_PULSE,
        ST_SAMPLE,
        ST_EVAL,
        ST_WAIT,
        ST_EXIT,
        ST_DONE
    } wl_state_e;

    localparam int unsigned LVL_MR_NUM = 1;
endpackage

// File: rtl/wl_vote.sv
// Majority vote over a fixed number of feedback samples.
// Assumes: clr comes before the first sample of a step; smp_en is high
// only while the sequencer is collecting samples.
module wl_vote #(
    parameter int unsigned VOTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp_en,
    input  logic smp_bit,
    output logic last_o,
    output logic vote_hi_o
);
    localparam int unsigned CNT_W = $clog2(VOTES + 1);

    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] ones_q;

    // Count the samples taken and the ones among them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            n_q    <= '0;
            ones_q <= '0;
        end else if (smp_en) begin
            n_q    <= n_q + 1'b1;
            ones_q <= ones_q + CNT_W'(smp_bit);
        end
    end

    // The final sample of the step is being accepted now.
    assign last_o = smp_en && (n_q == CNT_W'(VOTES - 1));

    // Strict majority; a tie counts as low.
    assign vote_hi_o = (2 * int'(ones_q)) > int'(VOTES);
endmodule

// File: rtl/wl_wait_timer.sv
// Programmable settling timer used between strobe groups.
// Assumes: load is pulsed one cycle before run starts; a value of 0 acts as 1.
module wl_wait_timer #(
    parameter int unsigned WAIT_W   = 8,
    parameter int unsigned WAIT_DEF = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WAIT_W-1:0] cfg_val,
    input  logic              load,
    input  logic              run,
    output logic              expire_o
);
    logic [WAIT_W-1:0] cfg_q;
    logic [WAIT_W-1:0] cnt_q;

    // Hold the programmed settling time.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= WAIT_W'(WAIT_DEF);
        else if (cfg_we) cfg_q <= cfg_val;
    end

    // Count down the settling time.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load)             cnt_q <= cfg_q;
        else if (run && !expire_o) cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q <= WAIT_W'(1));
endmodule

// File: rtl/wl_lane_bank.sv
// Per-lane delay code and error storage.
// Assumes: at most one of inc/zero is high in a cycle; ops hit the selected lane only.
module wl_lane_bank #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned DLY_W     = 7,
    parameter int unsigned LANE_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_all,
    input  logic [LANE_W-1:0]          sel,
    input  logic                       inc,
    input  logic                       zero,
    input  logic                       set_err,
    output logic [DLY_W-1:0]           cur_code,
    output logic [NUM_LANES*DLY_W-1:0] codes_o,
    output logic [NUM_LANES-1:0]       err_o
);
    logic [DLY_W-1:0] code_q [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Update this lane's code and error flag.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                code_q[g] <= '0;
                err_o[g]  <= 1'b0;
            end else if (sel == LANE_W'(g)) begin
                if (inc)          code_q[g] <= code_q[g] + 1'b1;
                else if (zero)    code_q[g] <= '0;
                if (set_err)      err_o[g]  <= 1'b1;
            end
        end
        assign codes_o[g*DLY_W +: DLY_W] = code_q[g];
    end

    // Select the code of the lane under training.
    always_comb begin
        cur_code = '0;
        for (int i = 0; i < NUM_LANES; i++)
            if (sel == LANE_W'(i)) cur_code = code_q[i];
    end
endmodule

// File: rtl/wl_level_ctrl.sv
// Strobe-to-clock leveling trainer: runs the entry command, then the per-lane
// delay search over majority-voted clock samples, then the exit command.
// Assumes: a front end turns dqs_fire into strobe pulses and returns VOTES
// samples per request; cmd_ack is a single-cycle accept for a pending cmd_req.
module wl_level_ctrl #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned DLY_W     = 7,
    parameter int unsigned VOTES     = 4,
    parameter int unsigned WAIT_W    = 8,
    parameter int unsigned WAIT_DEF  = 16,
    parameter int unsigned MR_W      = 16,
    parameter int unsigned LVL_BIT   = 7,
    localparam int unsigned LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       wait_we,
    input  logic [WAIT_W-1:0]          wait_val,
    output logic                       cmd_req,
    input  logic                       cmd_ack,
    output logic [2:0]                 cmd_mr_sel,
    output logic [MR_W-1:0]            cmd_mr_data,
    output logic                       dqs_fire,
    output logic [LANE_W-1:0]          lane_sel,
    input  logic                       fb_valid,
    input  logic                       fb_bit,
    output logic [NUM_LANES*DLY_W-1:0] dly_code,
    output logic                       busy,
    output logic                       done,
    output logic [NUM_LANES-1:0]       lane_err
);
    import wl_level_pkg::*;

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

    wl_state_e         state_q, state_d;
    logic [LANE_W-1:0] lane_q;
    logic              seen_zero_q;
    logic [DLY_W-1:0]  cur_code;
    logic              vote_last, vote_hi, wait_done;
    logic              go, in_eval, pass, fail, lane_end, at_max;

    assign go       = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign in_eval  = (state_q == ST_EVAL);
    assign at_max   = (cur_code == '1);
    assign pass     = vote_hi && seen_zero_q;
    assign fail     = !pass && at_max;
    assign lane_end = pass || fail;

    // Next-state selection for the training sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ENTER;
            ST_ENTER:  if (cmd_ack) state_d = ST_PULSE;
            ST_PULSE:  state_d = ST_SAMPLE;
            ST_SAMPLE: if (vote_last) state_d = ST_EVAL;
            ST_EVAL:   state_d = (lane_end && lane_q == LAST_LANE) ? ST_EXIT : ST_WAIT;
            ST_WAIT:   if (wait_done) state_d = ST_PULSE;
            ST_EXIT:   if (cmd_ack) state_d = ST_DONE;
            ST_DONE:   if (start) state_d = ST_ENTER;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Lane pointer: restart on a run, advance when a lane finishes.
    always_ff @(posedge clk) begin
        if (!rst_n || go)                            lane_q <= '0;
        else if (in_eval && lane_end && lane_q != LAST_LANE) lane_q <= lane_q + 1'b1;
    end

    // Remember whether the current lane has seen a low verdict yet.
    always_ff @(posedge clk) begin
        if (!rst_n || go)                 seen_zero_q <= 1'b0;
        else if (in_eval && lane_end)     seen_zero_q <= 1'b0;
        else if (in_eval && !vote_hi)     seen_zero_q <= 1'b1;
    end

    wl_vote #(.VOTES(VOTES)) u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == ST_PULSE),
        .smp_en    ((state_q == ST_SAMPLE) && fb_valid),
        .smp_bit   (fb_bit),
        .last_o    (vote_last),
        .vote_hi_o (vote_hi)
    );

    wl_wait_timer #(.WAIT_W(WAIT_W), .WAIT_DEF(WAIT_DEF)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (wait_we),
        .cfg_val  (wait_val),
        .load     (in_eval),
        .run      (state_q == ST_WAIT),
        .expire_o (wait_done)
    );

    wl_lane_bank #(.NUM_LANES(NUM_LANES), .DLY_W(DLY_W), .LANE_W(LANE_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (go),
        .sel      (lane_q),
        .inc      (in_eval && !lane_end),
        .zero     (in_eval && fail),
        .set_err  (in_eval && fail),
        .cur_code (cur_code),
        .codes_o  (dly_code),
        .err_o    (lane_err)
    );

    // Mode-register command outputs: leveling flag set on entry, cleared on exit.
    always_comb begin
        cmd_mr_data          = '0;
        cmd_mr_data[LVL_BIT] = (state_q == ST_ENTER);
    end
    assign cmd_req    = (state_q == ST_ENTER) || (state_q == ST_EXIT);
    assign cmd_mr_sel = 3'(LVL_MR_NUM);

    assign dqs_fire = (state_q == ST_PULSE);
    assign lane_sel = lane_q;
    assign done     = (state_q == ST_DONE);
    assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
endmodule

// File: rtl/wl_level_chk.sv
// Cycle-by-cycle properties of the leveling trainer, bound to the top.
// Assumes: observes ports only.
module wl_level_chk #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned DLY_W     = 7,
    parameter int unsigned MR_W      = 16,
    parameter int unsigned LVL_BIT   = 7,
    parameter int unsigned LANE_W    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       cmd_req,
    input logic                       cmd_ack,
    input logic [MR_W-1:0]            cmd_mr_data,
    input logic                       dqs_fire,
    input logic [LANE_W-1:0]          lane_sel,
    input logic [NUM_LANES*DLY_W-1:0] dly_code,
    input logic                       busy,
    input logic                       done,
    input logic [NUM_LANES-1:0]       lane_err
);
    // R2: a pending command and its data hold until acknowledged.
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_mr_data)));

    // R3: a strobe request lasts one cycle.
    a_r3_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_fire |=> !dqs_fire);

    // R3: strobe requests only inside a run and never alongside a command.
    a_r3_fire_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_fire |-> (busy && !cmd_req));

    // R9: done rises only right after the exit command is accepted.
    a_r9_done_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_req && cmd_ack && !cmd_mr_data[LVL_BIT]));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
        // R4: a lane code only steps up by one or falls to zero.
        a_r4_code_step: assert property (@(posedge clk) disable iff (!rst_n)
            (dly_code[g*DLY_W +: DLY_W] != $past(dly_code[g*DLY_W +: DLY_W])) |->
            ((dly_code[g*DLY_W +: DLY_W] == $past(dly_code[g*DLY_W +: DLY_W]) + 1'b1) ||
             (dly_code[g*DLY_W +: DLY_W] == '0)));

        // R7: an unselected lane's code is frozen during a run.
        a_r7_lane_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(busy) && $past(lane_sel) != LANE_W'(g)) |->
            $stable(dly_code[g*DLY_W +: DLY_W]));

        // R10: an error flag clears only after a start.
        a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lane_err[g]) |-> $past(start));
    end
endmodule

bind wl_level_ctrl wl_level_chk #(
    .NUM_LANES (NUM_LANES),
    .DLY_W     (DLY_W),
    .MR_W      (MR_W),
    .LVL_BIT   (LVL_BIT),
    .LANE_W    (LANE_W)
) u_wl_level_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cmd_req     (cmd_req),
    .cmd_ack     (cmd_ack),
    .cmd_mr_data (cmd_mr_data),
    .dqs_fire    (dqs_fire),
    .lane_sel    (lane_sel),
    .dly_code    (dly_code),
    .busy        (busy),
    .done        (done),
    .lane_err    (lane_err)
);

// File: tb/test_wl_level_ctrl.sv
module test_wl_level_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NL = 4;
    localparam int  DW = 7;
    localparam int  WW = 8;
    localparam int  MW = 16;
    localparam int  LIMIT = 150000;
    localparam int  NV = 3;

    // Stimulus: device threshold per lane and a noise flag; expected codes and error bits.
    localparam int VEC_TH   [NV][NL] = '{'{5, 1, 127, 40}, '{0, 200, 3, 64}, '{10, 90, 2, 33}};
    localparam int VEC_NOISE[NV]     = '{0, 1, 1};
    localparam int VEC_CODE [NV][NL] = '{'{5, 1, 127, 40}, '{0, 0, 3, 64}, '{10, 90, 2, 33}};
    localparam int VEC_ERR  [NV]     = '{0, 3, 0};

    logic clk = 0, rst_n = 0, start = 0, wait_we = 0, cmd_ack = 0, fb_valid = 0, fb_bit = 0;
    logic [WW-1:0] wait_val = '0;
    logic cmd_req, dqs_fire, busy, done;
    logic [2:0] cmd_mr_sel;
    logic [MW-1:0] cmd_mr_data;
    logic [1:0] lane_sel;
    logic [NL*DW-1:0] dly_code;
    logic [NL-1:0] lane_err;

    int total = 0, bad = 0, cycles = 0;
    int th_cur[NL];
    int noise = 0;
    int gap_cnt = 0, last_gap = 0;
    int cmd_cnt = 0;
    logic [MW-1:0] cmd_data_log[4];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wl_level_ctrl i_wl_level_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .wait_we(wait_we), .wait_val(wait_val),
        .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_mr_sel(cmd_mr_sel), .cmd_mr_data(cmd_mr_data),
        .dqs_fire(dqs_fire), .lane_sel(lane_sel), .fb_valid(fb_valid), .fb_bit(fb_bit),
        .dly_code(dly_code), .busy(busy), .done(done), .lane_err(lane_err)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device model: sampled clock is high once the lane code reaches the threshold.
    initial begin
        forever begin
            @(negedge clk);
            gap_cnt++;
            if (dqs_fire === 1'b1) begin
                int ln;
                int cd;
                logic smp;
                last_gap = gap_cnt;
                ln  = int'(lane_sel);
                cd  = int'(dly_code[ln*DW +: DW]);
                smp = (cd >= th_cur[ln]);
                @(negedge clk);
                for (int v = 0; v < 4; v++) begin
                    fb_valid = 1'b1;
                    fb_bit   = smp ^ ((noise != 0) && (v == 1));
                    @(negedge clk);
                end
                fb_valid = 1'b0;
                fb_bit   = 1'b0;
                gap_cnt  = 0;
            end
        end
    end

    // Command acceptor: records each request and acknowledges after a short delay.
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_req === 1'b1) begin
                if (cmd_cnt < 4) cmd_data_log[cmd_cnt] = cmd_mr_data;
                chk("R2 register select", int'(cmd_mr_sel), 1);
                @(negedge clk);
                if (cmd_mr_data[7] == 1'b0) chk("R9 done low before exit accepted", int'(done), 0);
                cmd_ack = 1'b1;
                cmd_cnt++;
                @(negedge clk);
                cmd_ack = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        while (cycles < LIMIT) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NL; i++) th_cur[i] = 0;
        repeat (3) @(negedge clk);
        // R1: state during and after reset.
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 cmd_req in reset", int'(cmd_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 codes after reset", int'(dly_code), 0);
        chk("R1 errors after reset", int'(lane_err), 0);
        chk("R1 fire after reset", int'(dqs_fire), 0);

        // Table-driven runs.
        for (int n = 0; n < NV; n++) begin
            for (int i = 0; i < NL; i++) th_cur[i] = VEC_TH[n][i];
            noise = VEC_NOISE[n];
            if (n == 2) begin
                // R8: program a shorter settling time.
                @(negedge clk);
                wait_we = 1'b1; wait_val = 8'd5;
                @(negedge clk);
                wait_we = 1'b0;
            end
            cmd_cnt = 0;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            // R10: run start clears results.
            chk("R10 codes cleared on start", int'(dly_code), 0);
            chk("R10 errors cleared on start", int'(lane_err), 0);
            chk("R2 busy after start", int'(busy), 1);
            if (n == 2) begin
                // R10: start during a run is ignored.
                repeat (200) @(negedge clk);
                pulse_start();
            end
            wait_done();
            for (int i = 0; i < NL; i++)
                chk($sformatf("R4 R5 R6 R7 lane %0d code run %0d", i, n),
                    int'(dly_code[i*DW +: DW]), VEC_CODE[n][i]);
            chk($sformatf("R6 error flags run %0d", n), int'(lane_err), VEC_ERR[n]);
            chk($sformatf("R9 R10 command count run %0d", n), cmd_cnt, 2);
            chk("R2 entry data", int'(cmd_data_log[0]), 16'h0080);
            chk("R9 exit data", int'(cmd_data_log[1]), 0);
            chk("R9 busy low when done", int'(busy), 0);
            // R8: gap counted from the bench's final-sample negedge (W+1 here).
            chk("R8 settling gap", last_gap, (n == 2) ? 6 : 17);
        end

        // R9: done holds until the next start.
        repeat (10) @(negedge clk);
        chk("R9 done held", int'(done), 1);

        // R3: tie case - two of four samples high reads as low, so threshold 2 with
        // alternating noise is not used; instead check single-flip majority on lane 0 high side.
        for (int i = 0; i < NL; i++) th_cur[i] = 1;
        noise = 1;
        cmd_cnt = 0;
        pulse_start();
        wait_done();
        for (int i = 0; i < NL; i++)
            chk($sformatf("R3 majority lane %0d", i), int'(dly_code[i*DW +: DW]), 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule